// File: doc/BRIEF.md
# Link Client Register Block with Half-Word Write Enables

This block is a small register slave on a simple APB-style bus, placed next to a PCIe controller core. It holds the general control word (operating mode and link-training enable), the enhanced training-enable mode bit, and two interrupt groups. The first group carries the four legacy INTx lines. The second, called misc here, records link events. For every writable control register, the upper 16 bits of the write data act as a per-bit write enable for the lower 16 bits. Software can therefore change single bits without a read-modify-write.

The legacy status follows the INTx inputs as live levels. The misc status latches two kinds of event: any edge on the data-link-layer link-up input, and a one-cycle reset-request pulse. Software clears misc bits by writing ones to them. Each group drives its own interrupt output, formed as the OR of its unmasked status bits.

A read-only link status word combines the training state with the two link-up flags. A link-up output reports a fully trained link.

Top module: `pcie_client_regs`

## Requirements
- R1: After reset, these registers read 0: general control (0x000), enhanced mode (0x180), legacy mask (0x01C) and misc status (0x010). Misc mask (0x024) reads 0x00000006.
- R2: On a write to a control register (0x000, 0x180, 0x01C, 0x024), bit n of [15:0] takes pwdata[n] only when pwdata[n+16] is 1, and otherwise keeps its value. Bits [31:16] always read 0.
- R3: General control at 0x000 stores all 16 bits and drives `ctrl_out`. Writing 0x00400040 sets bit 6 (root-complex mode). 0x00F00000 clears [7:4] (endpoint mode). 0x000C000C sets [3:2] (training on). 0x000C0008 leaves [3:2]=2'b10 (training off).
- R4: The enhanced-mode register at 0x180 stores only bit 4 and drives `enh_train_en`. All its other bits read 0.
- R5: Legacy status at 0x008 returns `intx_in` live in bits [3:0]. Legacy mask at 0x01C holds 4 bits, and a 1 masks the matching line.
- R6: `irq_legacy` is 1 exactly when some INTx line is 1 and its mask bit is 0, with no register delay.
- R7: Misc status at 0x010 uses bit 1 and bit 2. Bit 1 becomes 1 at the clock edge that first samples a changed `dll_link_up`, on either edge. Bit 2 becomes 1 at the edge that samples `rst_req` high.
- R8: Writing 0x010 clears each misc bit whose write-data bit is 1 and leaves the others alone. If a hardware set and a clear hit the same bit in one cycle, the bit ends at 1.
- R9: Misc mask at 0x024 holds bits [2:1], with 1 meaning masked. `irq_misc` is 1 exactly when some misc status bit is 1 and its mask bit is 0.
- R10: Link status at 0x300 returns `ltssm_state` in [5:0], `phy_link_up` in bit 16, `dll_link_up` in bit 17, and 0 elsewhere.
- R11: `link_up` is 1 only when `phy_link_up` and `dll_link_up` are both 1 and `ltssm_state` equals 0x11.
- R12: Reads of unmapped offsets return 0, and writes to them change no register. Every access completes in its access cycle with no wait or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, decoded from paddr |
| intx_in | input | 4 | Legacy interrupt levels |
| ltssm_state | input | 6 | Training state code |
| phy_link_up | input | 1 | Physical-layer link-up flag |
| dll_link_up | input | 1 | Data-link-layer link-up flag |
| rst_req | input | 1 | One-cycle hot/link-down reset request |
| ctrl_out | output | 16 | General control register contents |
| enh_train_en | output | 1 | Enhanced training-enable mode bit |
| irq_legacy | output | 1 | Combined unmasked legacy interrupt |
| irq_misc | output | 1 | Combined unmasked misc interrupt |
| link_up | output | 1 | Fully trained link indicator |

## Verification
A wrong write-enable decode shows as a control bit that moves or stays against its upper-half enable. It is visible on `ctrl_out` the cycle after the write, and on readback. A lost or stuck misc status bit shows in `irq_misc` and in the 0x010 readback one edge after the event or the clear. The same-cycle set-against-clear collision is driven on purpose, because a wrong priority there leaves no other trace. Mask polarity errors flip the interrupt outputs at once, since those outputs are combinational.

// File: rtl/pcie_client_regs.sv
module pcie_client_regs #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [3:0]        intx_in,
  input  logic [5:0]        ltssm_state,
  input  logic              phy_link_up,
  input  logic              dll_link_up,
  input  logic              rst_req,
  output logic [15:0]       ctrl_out,
  output logic              enh_train_en,
  output logic              irq_legacy,
  output logic              irq_misc,
  output logic              link_up
);
  localparam logic [ADDR_W-1:0] A_GEN   = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_LSTA  = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] A_MSTA  = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] A_LMSK  = ADDR_W'(12'h01C);
  localparam logic [ADDR_W-1:0] A_MMSK  = ADDR_W'(12'h024);
  localparam logic [ADDR_W-1:0] A_HRST  = ADDR_W'(12'h180);
  localparam logic [ADDR_W-1:0] A_LINK  = ADDR_W'(12'h300);
  localparam logic [5:0]        TRAINED = 6'h11;

  logic [15:0] gen_q;
  logic        enh_q;
  logic [3:0]  lmsk_q;
  logic [2:1]  mmsk_q, msta_q, msta_set;
  logic        dll_q;
  logic        wr;
  logic [15:0] wen, wval;

  assign wr   = psel & penable & pwrite;
  assign wen  = pwdata[31:16];
  assign wval = pwdata[15:0];

  function automatic logic [15:0] hw_upd(input logic [15:0] cur, input logic [15:0] en,
                                         input logic [15:0] val);
    return (cur & ~en) | (val & en);
  endfunction

  assign msta_set = {rst_req, dll_link_up ^ dll_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= '0;
      enh_q  <= 1'b0;
      lmsk_q <= '0;
      mmsk_q <= 2'b11;
      msta_q <= '0;
      dll_q  <= 1'b0;
    end else begin
      dll_q <= dll_link_up;
      if (wr && paddr == A_GEN)  gen_q  <= hw_upd(gen_q, wen, wval);
      if (wr && paddr == A_HRST) enh_q  <= wen[4] ? wval[4] : enh_q;
      if (wr && paddr == A_LMSK) lmsk_q <= hw_upd({12'b0, lmsk_q}, wen, wval)[3:0];
      if (wr && paddr == A_MMSK) mmsk_q <= hw_upd({13'b0, mmsk_q, 1'b0}, wen, wval)[2:1];
      if (wr && paddr == A_MSTA) msta_q <= (msta_q & ~wval[2:1]) | msta_set;
      else                       msta_q <= msta_q | msta_set;
    end
  end

  always_comb begin
    prdata = '0;
    unique case (paddr)
      A_GEN:   prdata[15:0] = gen_q;
      A_HRST:  prdata[4]    = enh_q;
      A_LSTA:  prdata[3:0]  = intx_in;
      A_LMSK:  prdata[3:0]  = lmsk_q;
      A_MSTA:  prdata[2:1]  = msta_q;
      A_MMSK:  prdata[2:1]  = mmsk_q;
      A_LINK:  prdata       = {14'b0, dll_link_up, phy_link_up, 10'b0, ltssm_state};
      default: prdata       = '0;
    endcase
  end

  assign ctrl_out     = gen_q;
  assign enh_train_en = enh_q;
  assign irq_legacy   = |(intx_in & ~lmsk_q);
  assign irq_misc     = |(msta_q & ~mmsk_q);
  assign link_up      = phy_link_up & dll_link_up & (ltssm_state == TRAINED);

  p_masked_bits_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == A_GEN) |=> ((ctrl_out & ~$past(pwdata[31:16])) ==
                                ($past(ctrl_out) & ~$past(pwdata[31:16]))));
  p_no_write_no_change_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(ctrl_out) && $stable(enh_train_en) && $stable(lmsk_q) && $stable(mmsk_q)));
  p_reset_req_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> msta_q[2]);
  p_dll_edge_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dll_link_up != dll_q) |=> msta_q[1]);
  p_full_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mmsk_q == 2'b11) |-> !irq_misc);
  p_trained_needs_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> (prdata[17:16] == 2'b11 || paddr != A_LINK));
endmodule

// File: tb/pcie_client_regs_tb.sv
module pcie_client_regs_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [3:0] intx_in = '0;
  logic [5:0] ltssm_state = '0;
  logic phy_link_up = 0, dll_link_up = 0, rst_req = 0;
  logic [15:0] ctrl_out;
  logic enh_train_en, irq_legacy, irq_misc, link_up;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pcie_client_regs #(.ADDR_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .intx_in(intx_in),
    .ltssm_state(ltssm_state), .phy_link_up(phy_link_up), .dll_link_up(dll_link_up),
    .rst_req(rst_req), .ctrl_out(ctrl_out), .enh_train_en(enh_train_en),
    .irq_legacy(irq_legacy), .irq_misc(irq_misc), .link_up(link_up));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; pwdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    paddr = a;
    #1 chk(req, prdata, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 gen", 12'h000, 0);
    rd_chk("R1 enh", 12'h180, 0);
    rd_chk("R1 lmsk", 12'h01C, 0);
    rd_chk("R1 msta", 12'h010, 0);
    rd_chk("R1 mmsk", 12'h024, 32'h6);
    chk("R1 irq_misc", {31'b0, irq_misc}, 0);
  endtask

  task automatic t_general;
    wr(12'h000, 32'h0040_0040); rd_chk("R3 rc mode", 12'h000, 32'h40);
    wr(12'h000, 32'h0000_FFFF); rd_chk("R2 no enable", 12'h000, 32'h40);
    wr(12'h000, 32'h000C_000C); rd_chk("R3 train on", 12'h000, 32'h4C);
    wr(12'h000, 32'h000C_0008); rd_chk("R3 train off", 12'h000, 32'h48);
    chk("R3 ctrl_out", {16'b0, ctrl_out}, 32'h48);
    wr(12'h000, 32'h00F0_0000); rd_chk("R3 ep mode", 12'h000, 32'h08);
    wr(12'h000, 32'hFFFF_A5A5); rd_chk("R2 upper not stored", 12'h000, 32'hA5A5);
  endtask

  task automatic t_hot;
    wr(12'h180, 32'hFFFF_FFFF); rd_chk("R4 only bit4", 12'h180, 32'h10);
    chk("R4 enh out", {31'b0, enh_train_en}, 1);
    wr(12'h180, 32'h0000_0000); rd_chk("R2 enh kept", 12'h180, 32'h10);
    wr(12'h180, 32'h0010_0000); rd_chk("R4 cleared", 12'h180, 0);
  endtask

  task automatic t_legacy;
    @(negedge clk); intx_in = 4'b0101;
    rd_chk("R5 live", 12'h008, 32'h5);
    chk("R6 irq on", {31'b0, irq_legacy}, 1);
    wr(12'h01C, 32'h0005_0005); rd_chk("R5 mask", 12'h01C, 32'h5);
    #1 chk("R6 masked", {31'b0, irq_legacy}, 0);
    @(negedge clk); intx_in = 4'b1010;
    #1 chk("R6 other lines", {31'b0, irq_legacy}, 1);
    wr(12'h01C, 32'h000F_0000); rd_chk("R5 unmask", 12'h01C, 0);
    @(negedge clk); intx_in = 4'b0000;
    #1 chk("R6 idle", {31'b0, irq_legacy}, 0);
  endtask

  task automatic t_misc;
    @(negedge clk); rst_req = 1;
    @(negedge clk); rst_req = 0;
    rd_chk("R7 rst req", 12'h010, 32'h4);
    chk("R9 masked", {31'b0, irq_misc}, 0);
    wr(12'h024, 32'h0006_0000); rd_chk("R9 unmask", 12'h024, 0);
    #1 chk("R9 irq", {31'b0, irq_misc}, 1);
    @(negedge clk); dll_link_up = 1;
    @(negedge clk); rd_chk("R7 dll rise", 12'h010, 32'h6);
    wr(12'h010, 32'h4); rd_chk("R8 w1c one", 12'h010, 32'h2);
    @(negedge clk); dll_link_up = 0;
    @(negedge clk); rd_chk("R7 dll fall", 12'h010, 32'h2);
    wr(12'h010, 32'h6); rd_chk("R8 w1c all", 12'h010, 0);
    #1 chk("R9 irq clear", {31'b0, irq_misc}, 0);
    @(negedge clk);
    psel = 1; penable = 1; pwrite = 1; paddr = 12'h010; pwdata = 32'h4; rst_req = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; pwdata = 0; rst_req = 0;
    rd_chk("R8 set wins", 12'h010, 32'h4);
    wr(12'h010, 32'h0); rd_chk("R8 zero no clear", 12'h010, 32'h4);
    wr(12'h024, 32'h0002_0002); wr(12'h010, 32'h4);
    rd_chk("R9 mask bit1", 12'h024, 32'h2);
  endtask

  task automatic t_link;
    @(negedge clk); ltssm_state = 6'h11; phy_link_up = 1; dll_link_up = 1;
    rd_chk("R10 status", 12'h300, 32'h0003_0011);
    chk("R11 up", {31'b0, link_up}, 1);
    @(negedge clk); ltssm_state = 6'h10;
    #1 chk("R11 wrong state", {31'b0, link_up}, 0);
    @(negedge clk); ltssm_state = 6'h11; phy_link_up = 0;
    #1 chk("R11 phy down", {31'b0, link_up}, 0);
    rd_chk("R10 dll only", 12'h300, 32'h0002_0011);
  endtask

  task automatic t_unmapped;
    wr(12'h004, 32'hFFFF_FFFF); rd_chk("R12 read 0", 12'h004, 0);
    wr(12'h104, 32'hFFFF_FFFF); rd_chk("R12 read 0 hi", 12'h104, 0);
    rd_chk("R12 gen kept", 12'h000, 32'hA5A5);
    rd_chk("R12 lmsk kept", 12'h01C, 0);
    rd_chk("R12 mmsk kept", 12'h024, 32'h2);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_general;
    t_hot;
    t_legacy;
    t_misc;
    t_link;
    t_unmapped;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule